// File: doc/BRIEF.md
# MDIO Station-Management Master

This block is a station-management master for PHY and PCS/PMA management slaves. It produces the management clock (MDC) from the host clock, using a 6-bit divide value. It sends a complete 64-bit management frame, MSB first. On reads it releases the data line so the slave can drive it, and it collects the 16 returned bits. The shared data line is handled through three separate signals for an external bidirectional pad: serial out, serial in, and an active-high release control.

The divide register comes out of reset at zero. While it is zero, no transaction can begin, whatever the two static enables say. A nonzero divide value `D` gives an MDC period of `2*(D+1)` host clocks. Software picks `D` so that MDC stays at or below 2.5 MHz. When the MDIO enable is high but host control is off, the block does not run frames. In that case the MDC output simply follows an external clock input, so another master can use the pins.

A transaction works as follows. Software loads the divide value, then presents the opcode, PHY address, register address and write data together with a one-cycle start. It waits for the done pulse. On a read, the result is then valid on the read-data output.

Top module: `mdio_mgmt_master`

## Requirements
- R1: After reset the divide register is 0, `busy_o` and `done_o` are low, `mdc_o` is low, `md_tri_o` is high and `md_out_o` is high.
- R2: A start is accepted only when `mdio_en_i` and `host_en_i` are both high and the divide register is nonzero. Otherwise it has no effect, and `busy_o` stays low.
- R3: While a frame runs with divide value D, MDC is low for D+1 host clocks and then high for D+1 host clocks, for each of the 64 bits. The low half of bit 0 begins in the cycle after the accepting edge.
- R4: The frame is sent MSB first as: 32 ones, `01`, the 2-bit opcode, the 5-bit PHY address, the 5-bit register address, turnaround, then 16 data bits. A write opcode is `01` and a read opcode is `10`; any other opcode is sent as a write.
- R5: `md_out_o` changes only when a start is accepted, at a falling MDC transition, or when the frame ends. It is therefore steady across every rising MDC edge.
- R6: On a read, `md_tri_o` is high from the first turnaround bit (frame bit 46) to the end of the frame. `md_in_i` is sampled at each rising MDC edge of the 16 data bits, MSB first, and the word is on `rdata_o` when `done_o` pulses.
- R7: On a write, `md_tri_o` is low for the whole frame and the turnaround bits are sent as `1` then `0`.
- R8: `busy_o` rises in the cycle after an accepted start. `done_o` is a one-cycle pulse that appears, together with `busy_o` falling, exactly 128*(D+1) host clocks after the accepting edge.
- R9: A start request made while `busy_o` is high is ignored and does not disturb the running frame.
- R10: Whenever no frame is running and host control is on, `mdc_o` is low, `md_tri_o` is high and `md_out_o` is high.
- R11: With `mdio_en_i` high and `host_en_i` low, `mdc_o` equals `ext_mdc_i` and starts are ignored. With `mdio_en_i` low, `mdc_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdio_en_i | input | 1 | Static management-port enable |
| host_en_i | input | 1 | Static host-control enable |
| div_wr_i | input | 1 | Write strobe for the divide register |
| div_wdata_i | input | 6 | New divide value |
| start_i | input | 1 | One-cycle transaction request |
| op_i | input | 2 | Opcode (01 write, 10 read) |
| phy_addr_i | input | 5 | Target PHY address |
| reg_addr_i | input | 5 | Target register address |
| wdata_i | input | 16 | Write data |
| ext_mdc_i | input | 1 | External MDC used when host control is off |
| md_in_i | input | 1 | Serial data from the pad |
| mdc_o | output | 1 | Management clock to the slaves |
| md_out_o | output | 1 | Serial data to the pad |
| md_tri_o | output | 1 | High releases the data line |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle end-of-frame pulse |
| rdata_o | output | 16 | Captured read data |

## Verification
The hardest case to reach is a start that arrives in the middle of a running read, combined with read data that must be sampled only on rising MDC edges. The bench drives `md_in_i` from its own model of the current bit, presenting the returned word only during data bits and holding the line high everywhere else. Any extra or shifted sample therefore corrupts the captured word. It also issues a second start while the read is in flight. The divide value is varied between frames so the half-period count changes, and the bench compares every output against its model on every clock. Blocked starts are provoked at zero divide, with the port disabled, and in external-clock mode, and `busy_o` and `mdc_o` are checked afterwards.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

    localparam int DIV_W      = 6;
    localparam int PHY_W      = 5;
    localparam int REG_W      = 5;
    localparam int DATA_W     = 16;
    localparam int OP_W       = 2;
    localparam int PRE_BITS   = 32;
    localparam int FRAME_BITS = PRE_BITS + 2 + OP_W + PHY_W + REG_W + 2 + DATA_W;
    localparam int IDX_W      = $clog2(FRAME_BITS);
    localparam int TA_POS     = FRAME_BITS - DATA_W - 2;
    localparam int DATA_POS   = FRAME_BITS - DATA_W;

    localparam logic [OP_W-1:0] OP_WRITE = 2'b01;
    localparam logic [OP_W-1:0] OP_READ  = 2'b10;

    typedef struct packed {
        logic [DIV_W-1:0] cnt;
        logic             level;
    } clk_state_t;

    typedef struct packed {
        logic                  busy;
        logic                  done;
        logic                  rd;
        logic [IDX_W-1:0]      idx;
        logic [FRAME_BITS-1:0] shreg;
        logic [DATA_W-1:0]     rdata;
    } frame_state_t;

    function automatic logic [FRAME_BITS-1:0] make_frame(
        input logic [OP_W-1:0]   op,
        input logic [PHY_W-1:0]  phy,
        input logic [REG_W-1:0]  rga,
        input logic [DATA_W-1:0] dat
    );
        logic [OP_W-1:0] op_eff;
        op_eff = (op == OP_READ) ? OP_READ : OP_WRITE;
        return {{PRE_BITS{1'b1}}, 2'b01, op_eff, phy, rga, 2'b10, dat};
    endfunction

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen
    import mdio_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             mdc_o,
    output logic             rise_o,
    output logic             fall_o
);

    clk_state_t st_d, st_q;
    logic       wrap;

    always_comb begin
        st_d   = st_q;
        wrap   = run_i && (st_q.cnt == div_i);
        rise_o = wrap && !st_q.level;
        fall_o = wrap &&  st_q.level;
        if (!run_i) begin
            st_d.cnt   = '0;
            st_d.level = 1'b0;
        end else if (wrap) begin
            st_d.cnt   = '0;
            st_d.level = !st_q.level;
        end else begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign mdc_o = st_q.level;

    // R3
    mdc_low_when_stopped_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_i |=> !mdc_o);

    // R3
    rise_makes_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise_o && run_i) |=> mdc_o);

endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [PHY_W-1:0]  phy_i,
    input  logic [REG_W-1:0]  reg_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              rise_i,
    input  logic              fall_i,
    input  logic              md_in_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              md_out_o,
    output logic              md_tri_o,
    output logic [DATA_W-1:0] rdata_o
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);
    localparam logic [IDX_W-1:0] TA_IDX   = IDX_W'(TA_POS);
    localparam logic [IDX_W-1:0] DATA_IDX = IDX_W'(DATA_POS);

    frame_state_t fs_d, fs_q;

    always_comb begin
        fs_d      = fs_q;
        fs_d.done = 1'b0;
        if (!fs_q.busy) begin
            if (start_i) begin
                fs_d.busy  = 1'b1;
                fs_d.idx   = '0;
                fs_d.rd    = (op_i == OP_READ);
                fs_d.shreg = make_frame(op_i, phy_i, reg_i, wdata_i);
            end
        end else begin
            if (rise_i && fs_q.rd && (fs_q.idx >= DATA_IDX)) begin
                fs_d.rdata = {fs_q.rdata[DATA_W-2:0], md_in_i};
            end
            if (fall_i) begin
                if (fs_q.idx == LAST_IDX) begin
                    fs_d.busy  = 1'b0;
                    fs_d.done  = 1'b1;
                    fs_d.shreg = '1;
                end else begin
                    fs_d.idx   = fs_q.idx + 1'b1;
                    fs_d.shreg = {fs_q.shreg[FRAME_BITS-2:0], 1'b1};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fs_q       <= '0;
            fs_q.shreg <= '1;
        end else begin
            fs_q <= fs_d;
        end
    end

    assign busy_o   = fs_q.busy;
    assign done_o   = fs_q.done;
    assign rdata_o  = fs_q.rdata;
    assign md_out_o = fs_q.shreg[FRAME_BITS-1];
    assign md_tri_o = !fs_q.busy || (fs_q.rd && (fs_q.idx >= TA_IDX));

    // R5
    out_steady_between_falls_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !fall_i) |=> $stable(md_out_o));

    // R8
    done_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: rtl/mdio_mgmt_master.sv
module mdio_mgmt_master
    import mdio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mdio_en_i,
    input  logic              host_en_i,
    input  logic              div_wr_i,
    input  logic [DIV_W-1:0]  div_wdata_i,
    input  logic              start_i,
    input  logic [OP_W-1:0]   op_i,
    input  logic [PHY_W-1:0]  phy_addr_i,
    input  logic [REG_W-1:0]  reg_addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic              ext_mdc_i,
    input  logic              md_in_i,
    output logic              mdc_o,
    output logic              md_out_o,
    output logic              md_tri_o,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] rdata_o
);

    logic [DIV_W-1:0] div_d, div_q;
    logic             port_on;
    logic             start_ok;
    logic             int_mdc;
    logic             mdc_rise;
    logic             mdc_fall;
    logic             busy_w;

    always_comb begin
        div_d = div_q;
        if (div_wr_i) div_d = div_wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end

    assign port_on  = mdio_en_i && host_en_i && (div_q != '0);
    assign start_ok = start_i && port_on && !busy_w;

    mdio_clkgen u_clkgen (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (busy_w),
        .div_i  (div_q),
        .mdc_o  (int_mdc),
        .rise_o (mdc_rise),
        .fall_o (mdc_fall)
    );

    mdio_frame u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (start_ok),
        .op_i     (op_i),
        .phy_i    (phy_addr_i),
        .reg_i    (reg_addr_i),
        .wdata_i  (wdata_i),
        .rise_i   (mdc_rise),
        .fall_i   (mdc_fall),
        .md_in_i  (md_in_i),
        .busy_o   (busy_w),
        .done_o   (done_o),
        .md_out_o (md_out_o),
        .md_tri_o (md_tri_o),
        .rdata_o  (rdata_o)
    );

    assign busy_o = busy_w;
    assign mdc_o  = !mdio_en_i ? 1'b0 : (host_en_i ? int_mdc : ext_mdc_i);

    // R2
    blocked_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !port_on) |=> !busy_o);

    // R10
    idle_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && mdio_en_i && host_en_i) |-> (!mdc_o && md_tri_o && md_out_o));

    // R8
    end_has_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R11
    no_mdc_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mdio_en_i |-> !mdc_o);

endmodule

// File: tb/mdio_mgmt_master_tb.sv
module mdio_mgmt_master_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        mdio_en = 1'b0, host_en = 1'b0, div_wr = 1'b0, start = 1'b0;
    logic [5:0]  div_wdata = '0;
    logic [1:0]  op = '0;
    logic [4:0]  phy = '0, rga = '0;
    logic [15:0] wdata = '0;
    logic        ext_mdc = 1'b0, md_in = 1'b1;
    logic        mdc, md_out, md_tri, busy, done;
    logic [15:0] rdata;

    int checks = 0;
    int errors = 0;

    // reference model state
    bit          m_busy = 0, m_done = 0, m_read = 0;
    int          m_t = 0;
    int          m_div = 0;
    bit [63:0]   m_frame = '0;
    bit [15:0]   m_pat = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    mdio_mgmt_master dut_i (
        .clk(clk), .rst_n(rst_n), .mdio_en_i(mdio_en), .host_en_i(host_en),
        .div_wr_i(div_wr), .div_wdata_i(div_wdata), .start_i(start), .op_i(op),
        .phy_addr_i(phy), .reg_addr_i(rga), .wdata_i(wdata), .ext_mdc_i(ext_mdc),
        .md_in_i(md_in), .mdc_o(mdc), .md_out_o(md_out), .md_tri_o(md_tri),
        .busy_o(busy), .done_o(done), .rdata_o(rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // behavioural model, advanced on each rising edge
    always @(posedge clk) begin
        if (!rst_n) begin
            m_busy = 0; m_done = 0; m_t = 0; m_div = 0;
        end else begin
            m_done = 0;
            if (m_busy) begin
                m_t++;
                if (m_t == 128 * (m_div + 1)) begin
                    m_busy = 0;
                    m_done = 1;
                end
            end else if (start && mdio_en && host_en && m_div != 0) begin
                m_busy = 1;
                m_t = 0;
                m_read = (op == 2'b10);
                m_frame = {32'hFFFF_FFFF, 2'b01, (op == 2'b10) ? 2'b10 : 2'b01, phy, rga, 2'b10, wdata};
            end
            if (div_wr) m_div = div_wdata;
        end
    end

    // compare every clock, a quarter period after the edge; then drive md_in
    always @(posedge clk) begin
        #(CLK_PERIOD/4);
        if (rst_n) begin
            int h, b;
            bit e_mdc, e_tri, e_out;
            h = m_div + 1;
            b = m_busy ? m_t / (2 * h) : 0;
            e_mdc = m_busy && ((m_t % (2 * h)) >= h);
            if (!mdio_en)      e_mdc = 0;
            else if (!host_en) e_mdc = ext_mdc;
            e_tri = m_busy ? (m_read && b >= 46) : 1'b1;
            e_out = m_busy ? m_frame[63 - b] : 1'b1;
            chk(mdc === e_mdc, "R3 R11 mdc", 32'(mdc), 32'(e_mdc));
            chk(md_tri === e_tri, "R6 R7 R10 tri", 32'(md_tri), 32'(e_tri));
            if (!e_tri) chk(md_out === e_out, "R4 R5 md_out", 32'(md_out), 32'(e_out));
            chk(busy === m_busy, "R8 R9 busy", 32'(busy), 32'(m_busy));
            chk(done === m_done, "R8 done", 32'(done), 32'(m_done));
            if (m_done && m_read) chk(rdata === m_pat, "R6 rdata", 32'(rdata), 32'(m_pat));
            md_in = (m_busy && b >= 48) ? m_pat[63 - b] : 1'b1;
        end
    end

    task automatic set_div(input logic [5:0] v);
        @(negedge clk); div_wr = 1; div_wdata = v;
        @(negedge clk); div_wr = 0;
    endtask

    task automatic pulse_start(input logic [1:0] o, input logic [4:0] p, input logic [4:0] r, input logic [15:0] d);
        @(negedge clk); start = 1; op = o; phy = p; rga = r; wdata = d;
        @(negedge clk); start = 0;
    endtask

    task automatic wait_done();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (m_done) return;
        end
        chk(0, "R8 done never seen", 0, 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        chk(0, "watchdog", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !mdc && md_tri && md_out, "R1 reset outputs",
            {busy, done, mdc, md_tri, md_out}, 5'b00011);

        // R2: divide still zero, start must be ignored
        mdio_en = 1; host_en = 1;
        pulse_start(2'b01, 5'h03, 5'h04, 16'h1234);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0, "R2 zero divide blocks start", 32'(busy), 0);

        // write frame at divide 1
        set_div(6'd1);
        pulse_start(2'b01, 5'h11, 5'h0A, 16'hA5C3);
        chk(busy === 1'b1, "R8 busy after start", 32'(busy), 1);
        wait_done();

        // read at divide 1 with an extra start mid-frame (R9)
        m_pat = 16'h3C5A;
        pulse_start(2'b10, 5'h02, 5'h1F, 16'h0000);
        repeat (100) @(negedge clk);
        pulse_start(2'b01, 5'h1E, 5'h01, 16'hFFFF);
        wait_done();
        chk(rdata === 16'h3C5A, "R6 R9 read word after ignored start", 32'(rdata), 32'h3C5A);

        // divide 3: write, then read
        set_div(6'd3);
        pulse_start(2'b01, 5'h1F, 5'h00, 16'h0001);
        wait_done();
        m_pat = 16'h8001;
        pulse_start(2'b10, 5'h00, 5'h15, 16'hBEEF);
        wait_done();
        chk(rdata === 16'h8001, "R6 read word divide 3", 32'(rdata), 32'h8001);

        // R2: port disabled
        @(negedge clk); mdio_en = 0;
        pulse_start(2'b01, 5'h01, 5'h01, 16'h0F0F);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && mdc === 1'b0, "R2 R11 disabled port", {busy, mdc}, 0);

        // R11: external clock mode
        @(negedge clk); mdio_en = 1; host_en = 0;
        for (int i = 0; i < 24; i++) begin
            @(negedge clk); ext_mdc = i[1];
            if (i == 5) start = 1;
            if (i == 6) start = 0;
        end
        @(negedge clk);
        chk(busy === 1'b0, "R11 start ignored in external mode", 32'(busy), 0);
        chk(mdc === ext_mdc, "R11 mdc follows external", 32'(mdc), 32'(ext_mdc));
        ext_mdc = 0; host_en = 1;

        // divide 5: read with alternating data, other opcode sent as write (R4)
        set_div(6'd5);
        m_pat = 16'hA55A;
        pulse_start(2'b10, 5'h15, 5'h0A, 16'h0000);
        wait_done();
        chk(rdata === 16'hA55A, "R6 read word divide 5", 32'(rdata), 32'hA55A);
        pulse_start(2'b11, 5'h0A, 5'h15, 16'h5AA5);
        wait_done();
        repeat (4) @(negedge clk);
        chk(!busy && md_tri && !mdc, "R10 idle after frames", {busy, md_tri, mdc}, 3'b010);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule